// File: doc/BRIEF.md
# DDR Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM interface and walks the memory through its mandatory start-up script after reset. It holds the clock enable low for a settling period and then raises it while driving NOP. It then issues, in a fixed order, a precharge of all banks, an extended mode write that enables the DLL, a mode write that resets the DLL, a second precharge of all banks, a programmable number of auto-refresh commands and a final mode write. A minimum gap is enforced after each command.

Every wait is a parameter counted in clock cycles, so simulation can use short values. The burst length code and burst type for the mode writes come from two inputs that are sampled in the cycle each mode write is issued. The read latency is fixed at the code 011. A done flag goes high once the final mode write has had its spacing and the DLL lock count, started at the DLL reset write, has run out. The controller's normal traffic may start at that point.

Command codes: NOP=0, precharge-all=1, extended mode write=2, mode write=3, refresh=4. Cycle numbers below count clock edges after reset release. Cycle 0 is the state before the first edge.

Top module: `ddr_init_seq`

## Requirements
- R1: From reset until cycle T_PWR-1, cke_o is 0 and cmd_o is NOP. At cycle T_PWR, cke_o rises with NOP, and it then stays 1 until the next reset.
- R2: At cycle T_PWR+1, precharge-all (code 1) is driven with addr_o bit 10 = 1, all other address bits 0 and ba_o = 0.
- R3: T_RP cycles after the first precharge-all, an extended mode write (code 2) is driven with ba_o = 01 and addr_o all zero, which enables the DLL.
- R4: T_MRD cycles after the extended write, a mode write (code 3) is driven with ba_o = 00 and the following address fields: bit 8 = 1 (DLL reset), bit 7 = 0, bits 6:4 = 011, bit 3 = burst type, bits 2:0 = burst code. All higher bits are 0.
- R5: T_MRD cycles after the DLL reset write, a second precharge-all is driven. T_RP cycles later the first of N_REF refresh commands (code 4) follows, and each further refresh comes T_RFC cycles after the previous one.
- R6: T_RFC cycles after the last refresh, the final mode write is driven with the same fields as in R4 except that bit 8 = 0.
- R7: In every cycle without a scripted command, cmd_o is NOP (code 0) with ba_o and addr_o at zero.
- R8: done_o rises in cycle max(final write + T_MRD, DLL reset write + T_DLL) + 1 and then stays high. While done_o is high, only NOP is driven.
- R9: Asserting rst_ni low at any time drops cke_o and done_o at once. After release, the script restarts from R1.
- R10: The burst code and burst type in each mode write are taken from burst_code_i and burst_type_i in the cycle that write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_code_i | input | 3 | Burst length code placed in address bits 2:0 of mode writes |
| burst_type_i | input | 1 | Burst type placed in address bit 3 (1 = interleaved) |
| cke_o | output | 1 | Clock enable to the memory |
| cmd_o | output | 3 | Command code |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| done_o | output | 1 | Initialization complete |

## Verification
A step register that holds a wrong value shows up on cmd_o in the first cycle of that step: a command is missing, duplicated, or issued with the wrong bank or address bits. A step counter that holds a wrong value moves the next command off its expected cycle by the same error. The bench compares every cycle of the script against a per-cycle expected trace, so a single misplaced edge is caught. A fault in the lock counter shows as done_o rising early or late against the absolute cycle computed from the DLL reset write.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_PREA = 3'd1,
    CMD_EMRS = 3'd2,
    CMD_MRS  = 3'd3,
    CMD_REF  = 3'd4
  } cmd_e;

  typedef enum logic [3:0] {
    S_PWR, S_CKE, S_PRE1, S_EMRS, S_MRS_RST,
    S_PRE2, S_REF, S_MRS_FIN, S_LOCK, S_DONE
  } step_e;

  localparam logic [2:0] LAT_CODE = 3'b011;
  localparam int BIT_AP  = 10;
  localparam int BIT_DLR = 8;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ddr_init_step_cnt.sv
module ddr_init_step_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             first_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == limit_i - CNT_W'(1));
endmodule

// File: rtl/ddr_init_lock_cnt.sv
module ddr_init_lock_cnt #(
  parameter int T_DLL = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic ok_o
);
  localparam int LW = $clog2(T_DLL + 1) + 1;
  logic [LW-1:0] cnt_q;

  assign ok_o = (cnt_q >= LW'(T_DLL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (en_i && !ok_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ddr_init_cmd_gen.sv
module ddr_init_cmd_gen
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  step_e             step_i,
  input  logic              first_i,
  input  logic [2:0]        burst_code_i,
  input  logic              burst_type_i,
  output cmd_e              cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] mode_word;

  // A7 stays low; latency code fixed
  assign mode_word = ADDR_W'({1'b0, LAT_CODE, burst_type_i, burst_code_i});

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    if (first_i) begin
      unique case (step_i)
        S_PRE1, S_PRE2: begin
          cmd_o          = CMD_PREA;
          addr_o[BIT_AP] = 1'b1;
        end
        S_EMRS: begin
          cmd_o = CMD_EMRS;
          ba_o  = BA_W'(1);
        end
        S_MRS_RST: begin
          cmd_o           = CMD_MRS;
          addr_o          = mode_word;
          addr_o[BIT_DLR] = 1'b1;
        end
        S_REF:     cmd_o = CMD_REF;
        S_MRS_FIN: begin
          cmd_o  = CMD_MRS;
          addr_o = mode_word;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int T_PWR  = 40,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 10,
  parameter int T_MRD  = 2,
  parameter int T_DLL  = 200,
  parameter int N_REF  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        burst_code_i,
  input  logic              burst_type_i,
  output logic              cke_o,
  output logic [2:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam int MAX_W = max2(max2(T_PWR, T_RP), max2(T_RFC, T_MRD));
  localparam int CNT_W = $clog2(MAX_W + 1) + 1;
  localparam int REF_W = $clog2(N_REF + 1);

  step_e            step_q, step_d;
  logic [REF_W-1:0] ref_q;
  logic [CNT_W-1:0] dur;
  logic             first, last, clr, ref_step, lock_ok;
  cmd_e             cmd;

  always_comb begin
    unique case (step_q)
      S_PWR:                      dur = CNT_W'(T_PWR);
      S_PRE1, S_PRE2:             dur = CNT_W'(T_RP);
      S_EMRS, S_MRS_RST, S_MRS_FIN: dur = CNT_W'(T_MRD);
      S_REF:                      dur = CNT_W'(T_RFC);
      default:                    dur = CNT_W'(1);
    endcase
  end

  always_comb begin
    step_d = step_q;
    unique case (step_q)
      S_PWR:     if (last) step_d = S_CKE;
      S_CKE:     if (last) step_d = S_PRE1;
      S_PRE1:    if (last) step_d = S_EMRS;
      S_EMRS:    if (last) step_d = S_MRS_RST;
      S_MRS_RST: if (last) step_d = S_PRE2;
      S_PRE2:    if (last) step_d = S_REF;
      S_REF:     if (last && ref_q == REF_W'(N_REF - 1)) step_d = S_MRS_FIN;
      S_MRS_FIN: if (last) step_d = S_LOCK;
      S_LOCK:    if (lock_ok) step_d = S_DONE;
      default:   step_d = S_DONE;
    endcase
  end

  assign ref_step = (step_q == S_REF) && last;
  assign clr      = (step_d != step_q) || ref_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= S_PWR;
      ref_q  <= '0;
    end else begin
      step_q <= step_d;
      if (ref_step) ref_q <= ref_q + 1'b1;
    end
  end

  ddr_init_step_cnt #(.CNT_W(CNT_W)) u_step_cnt (
    .clk_i, .rst_ni, .clr_i(clr), .limit_i(dur),
    .first_o(first), .last_o(last)
  );

  // lock window opens with the DLL reset write
  ddr_init_lock_cnt #(.T_DLL(T_DLL)) u_lock_cnt (
    .clk_i, .rst_ni,
    .en_i(step_q inside {S_MRS_RST, S_PRE2, S_REF, S_MRS_FIN, S_LOCK, S_DONE}),
    .ok_o(lock_ok)
  );

  ddr_init_cmd_gen #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_cmd_gen (
    .step_i(step_q), .first_i(first),
    .burst_code_i, .burst_type_i,
    .cmd_o(cmd), .ba_o, .addr_o
  );

  assign cmd_o  = cmd;
  assign cke_o  = (step_q != S_PWR);
  assign done_o = (step_q == S_DONE);
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 10,
  parameter int T_MRD  = 2,
  parameter int T_DLL  = 200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_o,
  input logic [2:0]        cmd_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);
  localparam logic [2:0] NOP = 3'd0, PREA = 3'd1, EMRS = 3'd2, MRS = 3'd3, REF = 3'd4;

  logic [15:0] gap_q, dll_q;
  logic [2:0]  last_q;
  logic        dll_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0; last_q <= NOP; dll_q <= '0; dll_seen_q <= 1'b0;
    end else begin
      if (cmd_o != NOP) begin
        gap_q  <= 16'd1;
        last_q <= cmd_o;
      end else if (gap_q != 16'hffff) gap_q <= gap_q + 1'b1;
      if (cmd_o == MRS && addr_o[8]) begin
        dll_q <= 16'd1; dll_seen_q <= 1'b1;
      end else if (dll_q != 16'hffff) dll_q <= dll_q + 1'b1;
    end
  end

  a_r1_cke_low_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> cmd_o == NOP);
  a_r1_cke_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);
  a_r5_rp_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != NOP && last_q == PREA) |-> gap_q >= 16'(T_RP));
  a_r5_rfc_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != NOP && last_q == REF) |-> gap_q >= 16'(T_RFC));
  a_r4_mrd_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != NOP && (last_q == MRS || last_q == EMRS)) |-> gap_q >= 16'(T_MRD));
  a_r8_done_after_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> dll_seen_q && dll_q >= 16'(T_DLL) && gap_q >= 16'(T_MRD));
  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  a_r8_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_o == NOP && cke_o);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .ADDR_W(ADDR_W), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .T_DLL(T_DLL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_o(cke_o), .cmd_o(cmd_o),
  .addr_o(addr_o), .done_o(done_o)
);

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;
  localparam int N = 260;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [2:0]  burst_code_i = 3'b011;
  logic        burst_type_i = 1'b0;
  logic        cke_o, done_o;
  logic [2:0]  cmd_o;
  logic [1:0]  ba_o;
  logic [12:0] addr_o;

  int total = 0, bad = 0;

  logic [2:0]  t_cmd [N];
  logic [1:0]  t_ba  [N];
  logic [12:0] t_addr[N];
  logic        t_cke [N];
  logic        t_done[N];

  // {cycle, cmd, ba, addr} for defaults, burst code 011, sequential
  localparam logic [33:0] SCRIPT [7] = '{
    {16'd41, 3'd1, 2'd0, 13'h0400},
    {16'd44, 3'd2, 2'd1, 13'h0000},
    {16'd46, 3'd3, 2'd0, 13'h0133},
    {16'd48, 3'd1, 2'd0, 13'h0400},
    {16'd51, 3'd4, 2'd0, 13'h0000},
    {16'd61, 3'd4, 2'd0, 13'h0000},
    {16'd71, 3'd3, 2'd0, 13'h0033}
  };

  ddr_init_seq u_dut (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run(input int n, input int chg_at, input logic [2:0] c2, input logic t2);
    for (int i = 0; i < n; i++) begin
      if (i == chg_at) begin burst_code_i = c2; burst_type_i = t2; end
      t_cmd[i] = cmd_o; t_ba[i] = ba_o; t_addr[i] = addr_o;
      t_cke[i] = cke_o; t_done[i] = done_o;
      @(posedge clk_i); @(negedge clk_i);
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int miss, ckefail;
    #1;
    chk("R1 reset cke", 32'(cke_o), 0);
    chk("R8 reset done", 32'(done_o), 0);
    do_reset();
    run(N, -1, 3'b011, 1'b0);

    // table walk: R2 R3 R4 R5 R6
    foreach (SCRIPT[k]) begin
      int c;
      c = int'(SCRIPT[k][33:18]);
      chk($sformatf("R2-6 step%0d cmd", k), 32'(t_cmd[c]), 32'(SCRIPT[k][17:15]));
      chk($sformatf("R2-6 step%0d ba", k), 32'(t_ba[c]), 32'(SCRIPT[k][14:13]));
      chk($sformatf("R2-6 step%0d addr", k), 32'(t_addr[c]), 32'(SCRIPT[k][12:0]));
    end
    chk("R4 dll reset addr", 32'(t_addr[46]), 32'h133);
    chk("R6 final addr", 32'(t_addr[71]), 32'h033);
    chk("R3 emrs", 32'(t_cmd[44]), 2);
    chk("R5 refresh2", 32'(t_cmd[61]), 4);
    chk("R2 first prea", 32'(t_addr[41]), 32'h400);

    // R7: every other cycle is a clean NOP
    miss = 0;
    for (int i = 0; i < N; i++) begin
      bit hit = 0;
      foreach (SCRIPT[k]) if (int'(SCRIPT[k][33:18]) == i) hit = 1;
      if (!hit && (t_cmd[i] != 0 || t_ba[i] != 0 || t_addr[i] != 0)) miss++;
    end
    chk("R7 idle nop cycles", 32'(miss), 0);

    // R1
    ckefail = 0;
    for (int i = 0; i < N; i++) if (t_cke[i] != (i >= 40)) ckefail++;
    chk("R1 cke profile", 32'(ckefail), 0);
    chk("R1 cke at 39", 32'(t_cke[39]), 0);
    chk("R1 cke at 40", 32'(t_cke[40]), 1);
    chk("R1 nop at 40", 32'(t_cmd[40]), 0);

    // R8: 46 + 200 + 1
    chk("R8 done low 246", 32'(t_done[246]), 0);
    chk("R8 done high 247", 32'(t_done[247]), 1);
    chk("R8 done holds", 32'(t_done[N-1]), 1);
    chk("R8 nop while done", 32'(t_cmd[N-1]), 0);

    // R9: async reset after done
    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk("R9 cke drops", 32'(cke_o), 0);
    chk("R9 done drops", 32'(done_o), 0);
    chk("R9 nop", 32'(cmd_o), 0);

    // R10: inputs sampled per write; R9 restart
    burst_code_i = 3'b001; burst_type_i = 1'b1;
    @(negedge clk_i); rst_ni = 1'b1;
    run(80, 50, 3'b010, 1'b0);
    chk("R9 restart cke", 32'(t_cke[39]), 0);
    chk("R9 restart prea", 32'(t_cmd[41]), 1);
    chk("R10 dll reset fields", 32'(t_addr[46]), 32'h139);
    chk("R10 final fields", 32'(t_addr[71]), 32'h032);
    chk("R10 final cmd", 32'(t_cmd[71]), 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule